// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the system side of an asynchronous parallel NOR flash. A client gives it one request at a time: program a word, erase a sector, erase the whole chip, lock the boot area, or read the maker and device codes. The sequencer turns the request into the unlock write cycles that the flash expects. It drives the chip-enable, write-enable and output-enable strobes and the address lines itself. It controls the data pins through an output-enable of its own. Every strobe phase lasts a number of clock cycles set by a parameter.

Once the last command cycle has been written, the block reads the flash repeatedly until the operation reports completion. Two completion rules are available: a bit-7 data comparison, or the bit-6 toggle check. A timeout counter limits the polling. If it expires, the block pulses the flash reset pin low and reports an error.

Before a program request writes anything, the block first reads the target word. If the new value would need a stored 0 to become 1, the block refuses the request.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and whenever `busy` is low, `f_ce_n`, `f_we_n`, `f_oe_n` and `f_rst_n` are 1 and `f_dq_oe` is 0.
- R2: A request with `op`=0 (program) first performs one read of `addr`. It then writes, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, and finally `wdata` to `addr`.
- R3: `op`=1 (sector erase), `op`=2 (chip erase) and `op`=3 (boot lock) each write six cycles: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA. The sixth cycle is 0x30 at `addr` for op 1, 0x10 at 0x5555 for op 2, and 0x40 at 0x5555 for op 3.
- R4: In every write cycle, `f_we_n` is low for exactly PULSE_CYC clocks. During that time `f_ce_n` is low and `f_oe_n` is high, and `f_addr` and `f_dq_o` do not change.
- R5: When `poll_dq6`=0, a program finishes on the first poll read whose bit 7 equals bit 7 of `wdata`. An erase or lock finishes on the first poll read whose bit 7 is 1.
- R6: When `poll_dq6`=1, an operation finishes when two consecutive poll reads return the same bit 6.
- R7: Between two read strobes, `f_oe_n` stays high for at least RGAP_CYC clocks.
- R8: A program request whose `wdata` has a 1 where the pre-read word has a 0 raises `err` and issues no write cycle.
- R9: `op`=4 writes 0xAA@0x5555, 0x55@0x2AAA and 0x90@0x5555. It then reads address 0 into `id_mfr` and address 1 into `id_dev`. It ends with a write of 0xF0 to 0x5555 and raises `done`.
- R10: If polling lasts TMO_CYC clocks without finishing, the block raises `err` and not `done`. It drives `f_rst_n` low for exactly RST_CYC clocks.
- R11: `done` and `err` are single-cycle pulses and are never high together. A `start` that arrives while `busy` is high is ignored.
- R12: `f_dq_oe` is never high while `f_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a request when idle |
| op | input | 3 | 0 program, 1 sector erase, 2 chip erase, 3 boot lock, 4 ID read |
| addr | input | AW | Target or sector address |
| wdata | input | DW | Word to program |
| poll_dq6 | input | 1 | 1 selects bit-6 toggle polling, 0 bit-7 polling |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Pulse on successful completion |
| err | output | 1 | Pulse on refusal or timeout |
| id_mfr | output | DW | Manufacturer code from the last ID read |
| id_dev | output | DW | Device code from the last ID read |
| f_ce_n | output | 1 | Flash chip enable, active low |
| f_we_n | output | 1 | Flash write strobe, active low |
| f_oe_n | output | 1 | Flash output enable, active low |
| f_rst_n | output | 1 | Flash reset, active low |
| f_addr | output | AW | Flash address |
| f_dq_o | output | DW | Data driven toward the flash |
| f_dq_oe | output | 1 | Enable for the data pin drivers |
| f_dq_i | input | DW | Data read from the flash |

## Verification
The bench uses a 16-bit address and 8-bit data. Each strobe phase is set to between 1 and 4 clocks, the polling timeout to 300 clocks, and the reset pulse to 6 clocks. With these short values, a stuck-busy flash reaches the timeout within a few dozen poll reads. They also let strobe widths and read gaps be counted to the exact clock. The behavioural flash model in the bench can be told to stay busy for a set number of reads, or to stay busy for ever. This drives both polling rules through their busy phase, their immediate-ready case and the timeout path.

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq #(
  parameter int AW        = 20,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 21,
  parameter int HOLD_CYC  = 2,
  parameter int WGAP_CYC  = 10,
  parameter int ACC_CYC   = 19,
  parameter int RGAP_CYC  = 31,
  parameter int TMO_CYC   = 2100000000,
  parameter int RST_CYC   = 200,
  parameter int UNLK_A    = 16'h5555,
  parameter int UNLK_B    = 16'h2AAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          poll_dq6,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] id_mfr,
  output logic [DW-1:0] id_dev,
  output logic          f_ce_n,
  output logic          f_we_n,
  output logic          f_oe_n,
  output logic          f_rst_n,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_dq_o,
  output logic          f_dq_oe,
  input  logic [DW-1:0] f_dq_i
);
  localparam int CW = 16;
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [2:0] OP_PROG = 3'd0, OP_SECT = 3'd1, OP_CHIP = 3'd2, OP_LOCK = 3'd3, OP_ID = 3'd4;
  localparam logic [CW-1:0] L_SET = CW'(SETUP_CYC - 1), L_PUL = CW'(PULSE_CYC - 1),
                            L_HLD = CW'(HOLD_CYC - 1), L_WGP = CW'(WGAP_CYC - 1),
                            L_ACC = CW'(ACC_CYC - 1), L_RGP = CW'(RGAP_CYC - 1),
                            L_RST = CW'(RST_CYC - 1);
  localparam logic [AW-1:0] UA = AW'(UNLK_A), UB = AW'(UNLK_B);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_CMD, S_POLL, S_IDR, S_EXIT, S_RSTP} st_t;
  typedef enum logic [1:0] {P_SET, P_PUL, P_HLD, P_GAP} ph_t;

  st_t           st;
  ph_t           ph;
  logic [CW-1:0] cnt;
  logic [2:0]    step;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rd_q;
  logic          mode_q, have_prev, prev6;
  logic [TW-1:0] tmo;
  logic          done_q, err_q;
  logic [DW-1:0] mfr_q, dev_q;

  logic          is_wr, bus_act, cyc_end, poll_fin, refuse;
  logic [2:0]    last_step;
  logic [AW-1:0] bus_a;
  logic [DW-1:0] bus_d;

  assign is_wr     = (st == S_CMD) || (st == S_EXIT);
  assign bus_act   = (st != S_IDLE) && (st != S_RSTP);
  assign cyc_end   = (ph == P_GAP) && (cnt == '0);
  assign last_step = (op_q == OP_PROG) ? 3'd3 : (op_q == OP_ID) ? 3'd2 : 3'd5;
  assign refuse    = |(~rd_q & data_q);
  assign poll_fin  = mode_q ? (have_prev && (rd_q[6] == prev6))
                            : ((op_q == OP_PROG) ? (rd_q[7] == data_q[7]) : rd_q[7]);

  always_comb begin
    bus_a = addr_q;
    bus_d = '0;
    case (st)
      S_CMD: begin
        case (step)
          3'd0: begin bus_a = UA; bus_d = DW'(8'hAA); end
          3'd1: begin bus_a = UB; bus_d = DW'(8'h55); end
          3'd2: begin
            bus_a = UA;
            bus_d = (op_q == OP_PROG) ? DW'(8'hA0) : (op_q == OP_ID) ? DW'(8'h90) : DW'(8'h80);
          end
          3'd3: begin
            if (op_q == OP_PROG) begin bus_a = addr_q; bus_d = data_q; end
            else begin bus_a = UA; bus_d = DW'(8'hAA); end
          end
          3'd4: begin bus_a = UB; bus_d = DW'(8'h55); end
          default: begin
            if (op_q == OP_SECT) begin bus_a = addr_q; bus_d = DW'(8'h30); end
            else begin bus_a = UA; bus_d = (op_q == OP_CHIP) ? DW'(8'h10) : DW'(8'h40); end
          end
        endcase
      end
      S_EXIT: begin bus_a = UA; bus_d = DW'(8'hF0); end
      S_IDR:  bus_a = AW'(step);
      default: bus_a = addr_q;
    endcase
  end

  assign f_addr  = bus_a;
  assign f_dq_o  = bus_d;
  assign f_ce_n  = !(bus_act && ph != P_GAP);
  assign f_we_n  = !(is_wr && ph == P_PUL);
  assign f_oe_n  = !(bus_act && !is_wr && ph == P_SET);
  assign f_dq_oe = is_wr && ph != P_GAP;
  assign f_rst_n = st != S_RSTP;
  assign busy    = st != S_IDLE;
  assign done    = done_q;
  assign err     = err_q;
  assign id_mfr  = mfr_q;
  assign id_dev  = dev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_SET; cnt <= '0; step <= '0;
      op_q <= '0; addr_q <= '0; data_q <= '0; rd_q <= '0; mode_q <= 1'b0;
      have_prev <= 1'b0; prev6 <= 1'b0; tmo <= '0;
      done_q <= 1'b0; err_q <= 1'b0; mfr_q <= '0; dev_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start && op <= OP_ID) begin
            op_q <= op; addr_q <= addr; data_q <= wdata; mode_q <= poll_dq6;
            step <= '0; ph <= P_SET; have_prev <= 1'b0; tmo <= '0;
            if (op == OP_PROG) begin st <= S_PRE; cnt <= L_ACC; end
            else begin st <= S_CMD; cnt <= L_SET; end
          end
        end
        S_RSTP: begin
          if (cnt == '0) begin st <= S_IDLE; err_q <= 1'b1; end
          else cnt <= cnt - 1'b1;
        end
        default: begin
          if (st == S_POLL && tmo == TW'(TMO_CYC - 1)) begin
            st <= S_RSTP; cnt <= L_RST;
          end else begin
            if (st == S_POLL) tmo <= tmo + 1'b1;
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              case (ph)
                P_SET: begin
                  if (is_wr) begin ph <= P_PUL; cnt <= L_PUL; end
                  else begin rd_q <= f_dq_i; ph <= P_GAP; cnt <= L_RGP; end
                end
                P_PUL: begin ph <= P_HLD; cnt <= L_HLD; end
                P_HLD: begin ph <= P_GAP; cnt <= L_WGP; end
                default: ;
              endcase
            end
            if (cyc_end) begin
              ph <= P_SET;
              case (st)
                S_PRE: begin
                  if (refuse) begin st <= S_IDLE; err_q <= 1'b1; end
                  else begin st <= S_CMD; step <= '0; cnt <= L_SET; end
                end
                S_CMD: begin
                  if (step == last_step) begin
                    st <= (op_q == OP_ID) ? S_IDR : S_POLL;
                    step <= '0; cnt <= L_ACC; tmo <= '0; have_prev <= 1'b0;
                  end else begin
                    step <= step + 1'b1; cnt <= L_SET;
                  end
                end
                S_POLL: begin
                  if (poll_fin) begin st <= S_IDLE; done_q <= 1'b1; end
                  else begin prev6 <= rd_q[6]; have_prev <= 1'b1; cnt <= L_ACC; end
                end
                S_IDR: begin
                  if (step == 3'd0) begin mfr_q <= rd_q; step <= 3'd1; cnt <= L_ACC; end
                  else begin dev_q <= rd_q; st <= S_EXIT; cnt <= L_SET; end
                end
                default: begin st <= S_IDLE; done_q <= 1'b1; end
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
`timescale 1ns/1ps
module flash_cmd_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int PULSE_CYC = 21,
  parameter int RGAP_CYC = 31,
  parameter int RST_CYC = 200
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          f_ce_n,
  input logic          f_we_n,
  input logic          f_oe_n,
  input logic          f_rst_n,
  input logic [AW-1:0] f_addr,
  input logic [DW-1:0] f_dq_o,
  input logic          f_dq_oe
);
  logic [15:0] we_lo, rst_lo, oe_hi;
  logic        seen_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_lo <= '0; rst_lo <= '0; oe_hi <= '0; seen_rd <= 1'b0;
    end else begin
      we_lo  <= f_we_n ? '0 : we_lo + 1'b1;
      rst_lo <= f_rst_n ? '0 : rst_lo + 1'b1;
      oe_hi  <= !f_oe_n ? '0 : (oe_hi == 16'hFFFF ? oe_hi : oe_hi + 1'b1);
      if (!f_oe_n) seen_rd <= 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (f_ce_n && f_we_n && f_oe_n && f_rst_n && !f_dq_oe));
  assert_strobe_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !f_we_n |-> (!f_ce_n && f_oe_n));
  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_we_n) |-> we_lo == 16'(PULSE_CYC));
  assert_strobe_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_we_n && $past(!f_we_n)) |-> ($stable(f_addr) && $stable(f_dq_o)));
  assert_read_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(f_oe_n) && seen_rd) |-> oe_hi >= 16'(RGAP_CYC));
  assert_rst_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_rst_n) |-> rst_lo == 16'(RST_CYC));
  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_no_contention_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !f_oe_n |-> !f_dq_oe);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .RGAP_CYC(RGAP_CYC), .RST_CYC(RST_CYC)
) u_chk (.*);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
  localparam int AW = 16, DW = 8;
  localparam int PULSE = 3, RGAP = 4, TMO = 300, RSTC = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, poll_dq6 = 1'b0;
  logic [2:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, err, f_ce_n, f_we_n, f_oe_n, f_rst_n, f_dq_oe;
  logic [DW-1:0] id_mfr, id_dev, f_dq_o, f_dq_i;
  logic [AW-1:0] f_addr;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .DW(DW), .SETUP_CYC(1), .PULSE_CYC(PULSE), .HOLD_CYC(1),
    .WGAP_CYC(2), .ACC_CYC(2), .RGAP_CYC(RGAP), .TMO_CYC(TMO), .RST_CYC(RSTC)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .poll_dq6(poll_dq6), .busy(busy), .done(done), .err(err), .id_mfr(id_mfr), .id_dev(id_dev),
    .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n), .f_rst_n(f_rst_n), .f_addr(f_addr),
    .f_dq_o(f_dq_o), .f_dq_oe(f_dq_oe), .f_dq_i(f_dq_i));

  // behavioural flash
  logic [7:0]  mem [16];
  logic [15:0] wla [64];
  logic [7:0]  wld [64];
  logic [15:0] lat_a;
  logic [7:0]  prevd, last_d, dq_r;
  logic        armed, kind_prog, tog, id_mode, stuck;
  int          wcount, busy_left, busy_set, nreads;
  assign f_dq_i = dq_r;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    wcount = 0; busy_left = 0; busy_set = 0; nreads = 0;
    armed = 0; kind_prog = 0; tog = 0; id_mode = 0; stuck = 0;
    prevd = 0; last_d = 0; dq_r = 0; lat_a = 0;
  end

  always @(negedge f_we_n) lat_a = f_addr;
  always @(posedge f_we_n) begin
    if (wcount < 64) begin wla[wcount] = lat_a; wld[wcount] = f_dq_o; end
    wcount++;
    if (armed) begin
      mem[lat_a[3:0]] = mem[lat_a[3:0]] & f_dq_o;
      armed = 0; kind_prog = 1; last_d = f_dq_o; busy_left = busy_set;
    end else if (prevd == 8'h55 && f_dq_o == 8'hA0) armed = 1;
    else if (prevd == 8'h55 && (f_dq_o == 8'h30 || f_dq_o == 8'h10)) begin
      for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
      kind_prog = 0; busy_left = busy_set;
    end else if (prevd == 8'h55 && f_dq_o == 8'h40) begin kind_prog = 0; busy_left = busy_set; end
    else if (prevd == 8'h55 && f_dq_o == 8'h90) id_mode = 1;
    else if (f_dq_o == 8'hF0) id_mode = 0;
    prevd = f_dq_o;
  end
  always @(negedge f_oe_n) begin
    nreads++;
    if (stuck || busy_left > 0) begin
      tog = ~tog;
      dq_r = kind_prog ? {~last_d[7], tog, 6'h0} : {1'b0, tog, 6'h0};
      if (!stuck) busy_left--;
    end else if (id_mode) dq_r = f_addr[0] ? 8'h22 : 8'h1F;
    else dq_r = mem[f_addr[3:0]];
  end
  always @(negedge f_rst_n) begin busy_left = 0; armed = 0; id_mode = 0; end

  // port monitors
  int wl = 0, last_wl = 0, oh = 0, min_oh = 1000, cont = 0, rl = 0, dcount = 0;
  bit seen = 0;
  always @(negedge clk) if (rst_n) begin
    if (!f_we_n) wl++; else if (wl != 0) begin last_wl = wl; wl = 0; end
    if (f_oe_n) oh++; else begin if (seen && oh != 0 && oh < min_oh) min_oh = oh; seen = 1; oh = 0; end
    if (!f_oe_n && f_dq_oe) cont++;
    if (!f_rst_n) rl++;
    if (done) dcount++;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit got_done, got_err;
  task automatic run_op(input logic [2:0] o, input logic [15:0] a, input logic [7:0] d, input logic m);
    @(negedge clk);
    op = o; addr = a; wdata = d; poll_dq6 = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 0; got_err = 0;
    for (int t = 0; t < 20000; t++) begin
      if (done) got_done = 1;
      if (err) got_err = 1;
      if (got_done || got_err) break;
      @(negedge clk);
    end
    if (!got_done && !got_err) chk("watchdog op", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0] op; logic [7:0] a; logic [7:0] d; logic m; logic [3:0] nbusy;
    logic xerr; logic [3:0] nw; logic [15:0] la; logic [7:0] ld; logic [7:0] xmem;
  } vec_t;
  localparam vec_t TBL [8] = '{
    '{3'd0, 8'h03, 8'h5A, 1'b0, 4'd3, 1'b0, 4'd4, 16'h0003, 8'h5A, 8'h5A},
    '{3'd0, 8'h03, 8'h50, 1'b1, 4'd4, 1'b0, 4'd4, 16'h0003, 8'h50, 8'h50},
    '{3'd0, 8'h03, 8'h5F, 1'b0, 4'd2, 1'b1, 4'd0, 16'h0000, 8'h00, 8'h50},
    '{3'd1, 8'h05, 8'h00, 1'b0, 4'd5, 1'b0, 4'd6, 16'h0005, 8'h30, 8'hFF},
    '{3'd2, 8'h03, 8'h00, 1'b1, 4'd3, 1'b0, 4'd6, 16'h5555, 8'h10, 8'hFF},
    '{3'd3, 8'h07, 8'h00, 1'b0, 4'd2, 1'b0, 4'd6, 16'h5555, 8'h40, 8'hFF},
    '{3'd4, 8'h00, 8'h00, 1'b0, 4'd0, 1'b0, 4'd4, 16'h5555, 8'hF0, 8'hFF},
    '{3'd0, 8'h07, 8'h00, 1'b1, 4'd0, 1'b0, 4'd4, 16'h0007, 8'h00, 8'h00}
  };

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 idle strobes in reset", {f_ce_n, f_we_n, f_oe_n, f_rst_n, f_dq_oe, busy}, 6'b111100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes after reset", {f_ce_n, f_we_n, f_oe_n, f_rst_n, f_dq_oe, busy}, 6'b111100);

    for (int i = 0; i < 8; i++) begin
      int w0, r0;
      vec_t v;
      v = TBL[i];
      w0 = wcount; r0 = nreads; busy_set = int'(v.nbusy);
      run_op(v.op, {8'h00, v.a}, v.d, v.m);
      chk($sformatf("R5 R6 R8 row%0d err flag", i), got_err, v.xerr);
      chk($sformatf("R5 R6 row%0d done flag", i), got_done, !v.xerr);
      chk($sformatf("R2 R3 R8 row%0d write count", i), wcount - w0, int'(v.nw));
      if (v.nw != 0) begin
        chk($sformatf("R2 R3 R9 row%0d last addr", i), wla[wcount-1], v.la);
        chk($sformatf("R2 R3 R9 row%0d last data", i), wld[wcount-1], v.ld);
      end
      chk($sformatf("R2 R8 row%0d stored word", i), mem[v.a[3:0]], v.xmem);
      if (i == 0) begin
        chk("R2 pre-read before writes", nreads - r0 > 1, 1);
        chk("R2 unlock 1", {wla[w0], wld[w0]}, {16'h5555, 8'hAA});
        chk("R2 unlock 2", {wla[w0+1], wld[w0+1]}, {16'h2AAA, 8'h55});
        chk("R2 unlock 3", {wla[w0+2], wld[w0+2]}, {16'h5555, 8'hA0});
      end
      if (i == 3) chk("R3 fourth erase cycle", {wla[w0+3], wld[w0+3]}, {16'h5555, 8'hAA});
      if (i == 6) begin
        chk("R9 entry code", wld[w0+2], 8'h90);
        chk("R9 maker code", id_mfr, 8'h1F);
        chk("R9 device code", id_dev, 8'h22);
        chk("R9 flash back in read mode", id_mode, 0);
      end
    end

    chk("R4 write strobe width", last_wl, PULSE);
    chk("R7 poll read gap", min_oh >= RGAP, 1);
    chk("R12 no bus contention", cont, 0);

    begin
      int w0, d0;
      w0 = wcount; d0 = dcount; busy_set = 20;
      @(negedge clk);
      op = 3'd2; poll_dq6 = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      op = 3'd0; addr = 16'h0002; wdata = 8'h00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
      repeat (40) @(negedge clk);
      chk("R11 start ignored while busy, writes", wcount - w0, 6);
      chk("R11 one done pulse", dcount - d0, 1);
      chk("R11 word untouched", mem[2], 8'hFF);
    end

    begin
      int w0, d0;
      w0 = wcount; d0 = dcount; rl = 0; stuck = 1;
      run_op(3'd0, 16'h0009, 8'h00, 1'b0);
      stuck = 0;
      chk("R10 timeout raises err", got_err, 1);
      chk("R10 no done on timeout", dcount - d0, 0);
      chk("R10 reset pulse width", rl, RSTC);
      chk("R10 command was issued", wcount - w0, 4);
      chk("R1 idle after timeout", {f_ce_n, f_we_n, f_oe_n, f_rst_n, f_dq_oe}, 5'b11110);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule